// File: doc/BRIEF.md
# Flash Read-to-Memory DMA Sequencer

This block runs one serial-flash read command on a single data lane and streams what the flash returns into a memory write port as 32-bit words. Software writes a set of registers over a simple word-wide register port. It provides the command byte and a 24-bit flash address, dummy-clock counts for three read styles, a count of preamble bytes to skip, the transfer length in words, and a 4 KiB-aligned destination base. It then sets a start bit. The block drives chip select, serial clock and the outgoing data line. It samples the incoming line, packs the data bytes into words and writes them to consecutive word addresses. On completion it raises a status bit, which can also drive an interrupt.

The serial clock runs in mode 0: it idles low, outgoing bits change on falling edges and incoming bits are sampled at the end of each high phase. Each half period lasts `HALF_DIV` system clocks. The command byte and the address are sent first, each most significant bit first. Next come the dummy clocks for the selected read style, then the preamble bytes, which are clocked in and discarded. The data follows.

Register map (byte offsets on `reg_addr`; bits not listed read as zero): 0x00 command (opcode 7:0, flash address 31:8); 0x04 wait (fast 4:0, dual I/O 12:8, quad I/O 20:16, preamble bytes 27:24); 0x08 length (15:0); 0x0C destination (base 31:12, ring end 5, size code 4:0); 0x10 control (buffer unit 3, receive reset 5); 0x14 go (start 3); 0x18 status (done 3); 0x1C mask (done enable 3).

Top module: `flash_read_dma`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, `mem_we` and `irq` are 0, and every register reads 0.
- R2: A read drives `spi_cs_n` low and sends the opcode (command bits 7:0) and then the 24-bit address (command bits 31:8) on `spi_mosi`, MSB first, with each bit valid at a rising edge of `spi_sclk`; chip select stays low with the clock idle whenever it is high.
- R3: The number of dummy clocks between the address and the data depends on the opcode. Opcodes 0x0B, 0x3B and 0x6B use wait bits 4:0, 0xBB uses bits 12:8 and 0xEB uses bits 20:16. Any other opcode has no dummy clocks.
- R4: Wait bits 27:24 give a number of bytes that are clocked in after the dummy clocks and never written to memory.
- R5: Data bytes are packed little-endian: the first byte received for a word lands in bits 7:0 and the fourth in bits 31:24, and each byte arrives MSB first.
- R6: Word i of a read is written to address {destination bits 31:12, 12'h000} + 4*i, so successive writes step by 4.
- R7: Length bits 15:0 hold the word count minus one. Any value above 1023 is clamped to 1024 words (4096 bytes).
- R8: Writing 1 to go bit 3 launches a read. The go register always reads 0.
- R9: A start request made while a read is in progress is ignored: that read keeps its frame and its writes, and no second read follows.
- R10: Completion sets status bit 3. Writing 1 to that bit clears it; writing 0 leaves it set.
- R11: `irq` equals status bit 3 AND mask bit 3.
- R12: Writing 1 to control bit 5 during a read ends it at once. Chip select goes high on the next clock, no further words are written and status bit 3 stays clear. Control bit 5 reads 0, while control bit 3 holds its written value.
- R13: Register fields read back as written, and undefined bits read 0: wait reads bits 27:24, 20:16, 12:8 and 4:0; length reads bits 15:0; destination reads bits 31:12 and 5:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_mosi | output | 1 | Outgoing serial data |
| spi_miso | input | 1 | Incoming serial data |
| mem_we | output | 1 | Memory word write strobe |
| mem_addr | output | 32 | Memory byte address of the word |
| mem_wdata | output | 32 | Memory write data |
| irq | output | 1 | Completion interrupt |

## Verification
The bound checker watches several things on every cycle. The serial clock must stay idle while chip select is high, and memory writes may occur only inside a read. Successive write addresses must step by four. A launch must pull chip select low on the next cycle. A normal completion must coincide with exactly the programmed number of word writes, and the done bit may fall only after a clear write. The bench's scenarios are what show the content of each frame. They check the opcode and address bits, the dummy-clock count chosen for each opcode, that preamble bytes are dropped and data is packed little-endian, and that long lengths are clamped. They also cover the register behaviour: masking, write-1-to-clear, an ignored second start and an abort part way through.

// File: rtl/fr_pkg.sv
package fr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_CMD   = 3'd1,
    PH_ADDR  = 3'd2,
    PH_DUMMY = 3'd3,
    PH_PRE   = 3'd4,
    PH_DATA  = 3'd5,
    PH_END   = 3'd6
  } phase_t;

  localparam logic [2:0] RIX_CMD  = 3'd0;
  localparam logic [2:0] RIX_WAIT = 3'd1;
  localparam logic [2:0] RIX_LEN  = 3'd2;
  localparam logic [2:0] RIX_DST  = 3'd3;
  localparam logic [2:0] RIX_CTL  = 3'd4;
  localparam logic [2:0] RIX_GO   = 3'd5;
  localparam logic [2:0] RIX_STAT = 3'd6;
  localparam logic [2:0] RIX_MASK = 3'd7;

  localparam logic [31:0] WAIT_KEEP = 32'h0F1F_1F1F;
  localparam logic [31:0] DST_KEEP  = 32'hFFFF_F03F;

  // Dummy-clock count chosen by the read opcode.
  function automatic logic [4:0] pick_dummy(input logic [7:0] op, input logic [31:0] waitw);
    case (op)
      8'h0B, 8'h3B, 8'h6B: pick_dummy = waitw[4:0];
      8'hBB:               pick_dummy = waitw[12:8];
      8'hEB:               pick_dummy = waitw[20:16];
      default:             pick_dummy = 5'd0;
    endcase
  endfunction

  // Length field holds words minus one; clamp to the transfer limit.
  function automatic int unsigned clamp_words(input logic [15:0] len, input int unsigned max_words);
    int unsigned n;
    n = int'(len) + 1;
    clamp_words = (n > max_words) ? max_words : n;
  endfunction

  // Phase that follows the current one; empty phases are skipped.
  function automatic phase_t next_phase(input phase_t cur, input logic has_dummy, input logic has_pre);
    case (cur)
      PH_CMD:   next_phase = PH_ADDR;
      PH_ADDR:  next_phase = has_dummy ? PH_DUMMY : (has_pre ? PH_PRE : PH_DATA);
      PH_DUMMY: next_phase = has_pre ? PH_PRE : PH_DATA;
      PH_PRE:   next_phase = PH_DATA;
      PH_DATA:  next_phase = PH_END;
      default:  next_phase = PH_IDLE;
    endcase
  endfunction

  // Byte address of a destination word.
  function automatic logic [31:0] word_addr(input logic [19:0] base, input logic [31:0] idx);
    word_addr = {base, 12'h000} + (idx << 2);
  endfunction

endpackage

// File: rtl/fr_regs.sv
module fr_regs
  import fr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        done_evt,
  output logic [31:0] cmd_word,
  output logic [31:0] wait_word,
  output logic [15:0] len_word,
  output logic [19:0] buf_base,
  output logic        start_req,
  output logic        rx_abort,
  output logic        stat_done,
  output logic        stat_clr_evt,
  output logic        irq
);

  logic [31:0] cmd_q, wait_q, dst_q;
  logic [15:0] len_q;
  logic        unit_q, done_q, mask_q;
  logic [2:0]  rix;

  assign rix = reg_addr[4:2];

  assign start_req    = reg_we && (rix == RIX_GO)   && reg_wdata[3];
  assign rx_abort     = reg_we && (rix == RIX_CTL)  && reg_wdata[5];
  assign stat_clr_evt = reg_we && (rix == RIX_STAT) && reg_wdata[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      wait_q <= '0;
      dst_q  <= '0;
      len_q  <= '0;
      unit_q <= 1'b0;
      mask_q <= 1'b0;
    end else if (reg_we) begin
      case (rix)
        RIX_CMD:  cmd_q  <= reg_wdata;
        RIX_WAIT: wait_q <= reg_wdata & WAIT_KEEP;
        RIX_LEN:  len_q  <= reg_wdata[15:0];
        RIX_DST:  dst_q  <= reg_wdata & DST_KEEP;
        RIX_CTL:  unit_q <= reg_wdata[3];
        RIX_MASK: mask_q <= reg_wdata[3];
        default: ;
      endcase
    end
  end

  // Completion wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            done_q <= 1'b0;
    else if (done_evt)     done_q <= 1'b1;
    else if (stat_clr_evt) done_q <= 1'b0;
  end

  always_comb begin
    case (rix)
      RIX_CMD:  reg_rdata = cmd_q;
      RIX_WAIT: reg_rdata = wait_q;
      RIX_LEN:  reg_rdata = {16'h0000, len_q};
      RIX_DST:  reg_rdata = dst_q;
      RIX_CTL:  reg_rdata = {28'h0, unit_q, 3'b000};
      RIX_STAT: reg_rdata = {28'h0, done_q, 3'b000};
      RIX_MASK: reg_rdata = {28'h0, mask_q, 3'b000};
      default:  reg_rdata = 32'h0;
    endcase
  end

  assign cmd_word  = cmd_q;
  assign wait_word = wait_q;
  assign len_word  = len_q;
  assign buf_base  = dst_q[31:12];
  assign stat_done = done_q;
  assign irq       = done_q & mask_q;

endmodule

// File: rtl/fr_serial.sv
module fr_serial
  import fr_pkg::*;
#(
  parameter int unsigned HALF_DIV  = 1,
  parameter int unsigned MAX_WORDS = 1024,
  parameter int unsigned WCNT_W    = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [7:0]        opcode,
  input  logic [23:0]       faddr,
  input  logic [4:0]        dummy_n,
  input  logic [3:0]        pre_n,
  input  logic [15:0]       len_field,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              busy,
  output logic              start_acc,
  output logic              done_evt,
  output logic [WCNT_W-1:0] run_words,
  output logic              byte_valid,
  output logic [7:0]        byte_data
);

  localparam int unsigned LEFT_W = WCNT_W + 5;
  localparam int unsigned DIV_W  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  phase_t             ph_q, nxt_ph;
  logic [DIV_W-1:0]   div_q;
  logic               sclk_q, cs_n_q, mosi_q;
  logic [30:0]        tx_q;
  logic [6:0]         rx_q;
  logic [2:0]         rxc_q;
  logic [4:0]         dum_q;
  logic [3:0]         pre_q;
  logic [WCNT_W-1:0]  words_q;
  logic [LEFT_W-1:0]  left_q, load_left;
  logic               active, tick, fall, receiving;

  assign active    = (ph_q != PH_IDLE) && (ph_q != PH_END);
  assign tick      = (div_q == DIV_W'(HALF_DIV - 1));
  assign fall      = active && tick && sclk_q;
  assign receiving = (ph_q == PH_PRE) || (ph_q == PH_DATA);
  assign start_acc = start && (ph_q == PH_IDLE) && !abort;

  always_comb begin
    nxt_ph = next_phase(ph_q, dum_q != 5'd0, pre_q != 4'd0);
    case (nxt_ph)
      PH_ADDR:  load_left = LEFT_W'(23);
      PH_DUMMY: load_left = LEFT_W'(dum_q) - LEFT_W'(1);
      PH_PRE:   load_left = (LEFT_W'(pre_q) << 3) - LEFT_W'(1);
      PH_DATA:  load_left = (LEFT_W'(words_q) << 5) - LEFT_W'(1);
      default:  load_left = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      div_q   <= '0;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      mosi_q  <= 1'b0;
      tx_q    <= '0;
      rx_q    <= '0;
      rxc_q   <= '0;
      dum_q   <= '0;
      pre_q   <= '0;
      words_q <= '0;
      left_q  <= '0;
    end else if (abort) begin
      ph_q   <= PH_IDLE;
      div_q  <= '0;
      sclk_q <= 1'b0;
      cs_n_q <= 1'b1;
      mosi_q <= 1'b0;
    end else if (start_acc) begin
      ph_q    <= PH_CMD;
      div_q   <= '0;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b0;
      mosi_q  <= opcode[7];
      tx_q    <= {opcode[6:0], faddr};
      rxc_q   <= '0;
      dum_q   <= dummy_n;
      pre_q   <= pre_n;
      words_q <= WCNT_W'(clamp_words(len_field, MAX_WORDS));
      left_q  <= LEFT_W'(7);
    end else if (ph_q == PH_END) begin
      ph_q   <= PH_IDLE;
      cs_n_q <= 1'b1;
    end else if (active) begin
      if (tick) begin
        div_q  <= '0;
        sclk_q <= ~sclk_q;
      end else begin
        div_q <= div_q + DIV_W'(1);
      end
      if (fall) begin
        mosi_q <= tx_q[30];
        tx_q   <= {tx_q[29:0], 1'b0};
        if (receiving) begin
          rx_q  <= {rx_q[5:0], spi_miso};
          rxc_q <= rxc_q + 3'd1;
        end
        if (left_q == '0) begin
          ph_q   <= nxt_ph;
          left_q <= load_left;
        end else begin
          left_q <= left_q - LEFT_W'(1);
        end
      end
    end
  end

  assign spi_sclk   = sclk_q;
  assign spi_cs_n   = cs_n_q;
  assign spi_mosi   = mosi_q;
  assign busy       = (ph_q != PH_IDLE);
  assign done_evt   = (ph_q == PH_END) && !abort;
  assign run_words  = words_q;
  assign byte_valid = fall && (ph_q == PH_DATA) && (rxc_q == 3'd7);
  assign byte_data  = {rx_q, spi_miso};

endmodule

// File: rtl/fr_packer.sv
module fr_packer
  import fr_pkg::*;
#(
  parameter int unsigned WORD_BYTES = 4,
  parameter int unsigned WCNT_W     = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic [19:0] base_in,
  input  logic        byte_valid,
  input  logic [7:0]  byte_data,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata
);

  localparam int unsigned LIDX_W = $clog2(WORD_BYTES);

  logic [LIDX_W-1:0]     lane_q;
  logic [7:0]            lane_b [WORD_BYTES-1];
  logic [WCNT_W-1:0]     widx_q;
  logic [19:0]           base_q;
  logic [8*WORD_BYTES-1:0] word_nxt;
  logic                  last_lane;

  assign last_lane = (lane_q == LIDX_W'(WORD_BYTES - 1));

  // One holding register per lower byte lane.
  for (genvar g = 0; g < WORD_BYTES - 1; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      lane_b[g] <= '0;
      else if (clear)                                  lane_b[g] <= '0;
      else if (byte_valid && lane_q == LIDX_W'(g))     lane_b[g] <= byte_data;
    end
    assign word_nxt[8*g +: 8] = lane_b[g];
  end
  assign word_nxt[8*(WORD_BYTES-1) +: 8] = byte_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q    <= '0;
      widx_q    <= '0;
      base_q    <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (clear) begin
      lane_q <= '0;
      widx_q <= '0;
      base_q <= base_in;
      mem_we <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      if (byte_valid) begin
        lane_q <= lane_q + LIDX_W'(1);
        if (last_lane) begin
          mem_we    <= 1'b1;
          mem_addr  <= word_addr(base_q, 32'(widx_q));
          mem_wdata <= word_nxt;
          widx_q    <= widx_q + WCNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/flash_read_dma.sv
module flash_read_dma
  import fr_pkg::*;
#(
  parameter int unsigned HALF_DIV  = 1,
  parameter int unsigned MAX_BYTES = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic        irq
);

  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned MAX_WORDS  = MAX_BYTES / WORD_BYTES;
  localparam int unsigned WCNT_W     = $clog2(MAX_WORDS + 1);

  logic [31:0]       cmd_word, wait_word;
  logic [15:0]       len_word;
  logic [19:0]       buf_base;
  logic              start_req, rx_abort, stat_done, stat_clr_evt;
  logic              busy, start_acc, done_evt;
  logic [WCNT_W-1:0] run_words;
  logic              byte_valid;
  logic [7:0]        byte_data;
  logic [4:0]        dummy_sel;

  assign dummy_sel = pick_dummy(cmd_word[7:0], wait_word);

  fr_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .done_evt     (done_evt),
    .cmd_word     (cmd_word),
    .wait_word    (wait_word),
    .len_word     (len_word),
    .buf_base     (buf_base),
    .start_req    (start_req),
    .rx_abort     (rx_abort),
    .stat_done    (stat_done),
    .stat_clr_evt (stat_clr_evt),
    .irq          (irq)
  );

  fr_serial #(
    .HALF_DIV  (HALF_DIV),
    .MAX_WORDS (MAX_WORDS),
    .WCNT_W    (WCNT_W)
  ) u_serial (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_req),
    .abort      (rx_abort),
    .opcode     (cmd_word[7:0]),
    .faddr      (cmd_word[31:8]),
    .dummy_n    (dummy_sel),
    .pre_n      (wait_word[27:24]),
    .len_field  (len_word),
    .spi_sclk   (spi_sclk),
    .spi_cs_n   (spi_cs_n),
    .spi_mosi   (spi_mosi),
    .spi_miso   (spi_miso),
    .busy       (busy),
    .start_acc  (start_acc),
    .done_evt   (done_evt),
    .run_words  (run_words),
    .byte_valid (byte_valid),
    .byte_data  (byte_data)
  );

  fr_packer #(
    .WORD_BYTES (WORD_BYTES),
    .WCNT_W     (WCNT_W)
  ) u_packer (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start_acc | rx_abort),
    .base_in    (buf_base),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata)
  );

endmodule

// File: rtl/flash_read_dma_chk.sv
module flash_read_dma_chk #(
  parameter int unsigned WCNT_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_cs_n,
  input logic              spi_sclk,
  input logic              mem_we,
  input logic [31:0]       mem_addr,
  input logic              busy,
  input logic              start_acc,
  input logic              done_evt,
  input logic [WCNT_W-1:0] run_words,
  input logic              stat_done,
  input logic              stat_clr_evt
);

  logic [WCNT_W-1:0] wr_cnt;
  logic [31:0]       prev_addr;
  logic              first_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_cnt    <= '0;
      prev_addr <= '0;
      first_wr  <= 1'b1;
    end else if (start_acc) begin
      wr_cnt   <= '0;
      first_wr <= 1'b1;
    end else if (mem_we) begin
      wr_cnt    <= wr_cnt + WCNT_W'(1);
      prev_addr <= mem_addr;
      first_wr  <= 1'b0;
    end
  end

  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  // R12
  write_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !first_wr) |-> (mem_addr == prev_addr + 32'd4));

  // R8
  launch_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> !spi_cs_n);

  // R7
  word_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> ((wr_cnt + WCNT_W'(mem_we)) == run_words));

  // R10
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_done) |-> $past(stat_clr_evt));

endmodule

bind flash_read_dma flash_read_dma_chk #(.WCNT_W(WCNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .spi_cs_n     (spi_cs_n),
  .spi_sclk     (spi_sclk),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .busy         (busy),
  .start_acc    (start_acc),
  .done_evt     (done_evt),
  .run_words    (run_words),
  .stat_done    (stat_done),
  .stat_clr_evt (stat_clr_evt)
);

// File: tb/flash_read_dma_bench.sv
module flash_read_dma_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_CMD = 5'h00, A_WAIT = 5'h04, A_LEN = 5'h08, A_DST = 5'h0C,
                         A_CTL = 5'h10, A_GO = 5'h14, A_STAT = 5'h18, A_MASK = 5'h1C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        spi_sclk, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;
  logic        mem_we, irq;
  logic [31:0] mem_addr, mem_wdata;

  int nchk = 0;
  int nerr = 0;

  // Reference model state
  logic [31:0] exp_addr[$];
  logic [31:0] exp_data[$];
  logic [7:0]  seed = 8'h00;
  int          lead_bits = 32;
  int          bitn = 0;
  int          sclk_rises = 0;
  logic [31:0] rx_cmd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_read_dma u_flash_read_dma (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq(irq)
  );

  function automatic logic [7:0] sbyte(input int k);
    return 8'(k * 37 + 29) ^ seed;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Behavioural flash: captures the command, counts clocks, returns a byte stream.
  always @(negedge spi_cs_n) begin
    bitn = 0; sclk_rises = 0; rx_cmd = '0; spi_miso = 1'b0;
  end
  always @(posedge spi_sclk) begin
    if (bitn < 32) rx_cmd = {rx_cmd[30:0], spi_mosi};
    sclk_rises++;
  end
  always @(negedge spi_sclk) begin
    logic [7:0] b;
    int k;
    bitn++;
    if (bitn >= lead_bits) begin
      k = bitn - lead_bits;
      b = sbyte(k / 8);
      spi_miso = b[7 - (k % 8)];
    end else spi_miso = 1'b0;
  end

  // Every clock: writes must match the expected stream exactly.
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_addr.size() == 0) chk("R9", "unexpected write addr", mem_addr, 32'hxxxx_xxxx);
      else begin
        chk("R6", "write address", mem_addr, exp_addr.pop_front());
        chk("R5", "write data", mem_wdata, exp_data.pop_front());
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic launch(input logic [7:0] op, input logic [23:0] fa, input logic [31:0] waitw,
                        input logic [15:0] len, input logic [31:0] dst, input int dum, input int words);
    int pre;
    pre = int'(waitw[27:24]);
    seed = fa[7:0];
    lead_bits = 32 + dum;
    wr(A_STAT, 32'h8);
    wr(A_CMD, {fa, op});
    wr(A_WAIT, waitw);
    wr(A_LEN, {16'h0, len});
    wr(A_DST, dst);
    for (int w = 0; w < words; w++) begin
      logic [31:0] d;
      for (int b = 0; b < 4; b++) d[8*b +: 8] = sbyte(pre + 4*w + b);
      exp_addr.push_back({dst[31:12], 12'h000} + 32'(4*w));
      exp_data.push_back(d);
    end
    wr(A_GO, 32'h8);
  endtask

  task automatic wait_done(output bit ok);
    logic [31:0] d;
    ok = 0;
    for (int i = 0; i < 80000; i++) begin
      rd(A_STAT, d);
      if (d[3]) begin ok = 1; break; end
    end
  endtask

  task automatic finish_read(input string req, input logic [7:0] op, input logic [23:0] fa,
                             input int dum, input int pre, input int words);
    bit ok;
    wait_done(ok);
    chk("R10", "done status set", 32'(ok), 32'd1);
    chk("R2", "opcode and address sent", rx_cmd, {op, fa});
    chk(req, "serial clock count", 32'(sclk_rises), 32'(32 + dum + 8*pre + 32*words));
    chk("R6", "all expected words written", 32'(exp_addr.size()), 32'd0);
    chk("R2", "chip select released", 32'(spi_cs_n), 32'd1);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1", "cs_n", 32'(spi_cs_n), 32'd1);
    chk("R1", "sclk", 32'(spi_sclk), 32'd0);
    chk("R1", "mem_we", 32'(mem_we), 32'd0);
    chk("R1", "irq", 32'(irq), 32'd0);
    for (int a = 0; a < 8; a++) begin
      rd(5'(4*a), d);
      chk("R1", "register reset value", d, 32'd0);
    end

    // R13 readback masks, R8 go reads zero, R12 control bits
    wr(A_WAIT, 32'hFFFF_FFFF); rd(A_WAIT, d); chk("R13", "wait readback", d, 32'h0F1F_1F1F);
    wr(A_DST, 32'hFFFF_FFFF);  rd(A_DST, d);  chk("R13", "destination readback", d, 32'hFFFF_F03F);
    wr(A_LEN, 32'hABCD_1234);  rd(A_LEN, d);  chk("R13", "length readback", d, 32'h0000_1234);
    wr(A_CTL, 32'h0000_0028);  rd(A_CTL, d);  chk("R12", "control readback", d, 32'h0000_0008);
    rd(A_GO, d); chk("R8", "go reads zero", d, 32'd0);
    chk("R8", "no launch from other writes", 32'(spi_cs_n), 32'd1);

    // Plain read, no dummy, no preamble, 4 words, irq masked off
    launch(8'h03, 24'h123456, 32'h0000_0005, 16'd3, 32'h0004_0ABC, 0, 4);
    rd(A_GO, d); chk("R8", "go reads zero after launch", d, 32'd0);
    finish_read("R3", 8'h03, 24'h123456, 0, 0, 4);
    chk("R11", "irq masked", 32'(irq), 32'd0);

    // Fast read with dummy and preamble, mask on
    wr(A_MASK, 32'h8);
    launch(8'h0B, 24'hA5C3E1, 32'h0206_0408, 16'd1, 32'h1234_5000, 8, 2);
    finish_read("R4", 8'h0B, 24'hA5C3E1, 8, 2, 2);
    chk("R11", "irq with mask", 32'(irq), 32'd1);
    wr(A_STAT, 32'h0); rd(A_STAT, d); chk("R10", "write 0 keeps done", d, 32'h8);
    wr(A_STAT, 32'h8); rd(A_STAT, d); chk("R10", "write 1 clears done", d, 32'h0);
    chk("R11", "irq after clear", 32'(irq), 32'd0);

    // Dual I/O and quad I/O dummy selection, single word
    launch(8'hBB, 24'h00FF00, 32'h0006_0408, 16'd0, 32'h0000_1000, 4, 1);
    finish_read("R3", 8'hBB, 24'h00FF00, 4, 0, 1);
    launch(8'hEB, 24'h800001, 32'h0006_0408, 16'd0, 32'h0000_2000, 6, 1);
    finish_read("R3", 8'hEB, 24'h800001, 6, 0, 1);

    // Start while busy is ignored
    launch(8'h03, 24'h0F0F0F, 32'h0, 16'd3, 32'h0008_0000, 0, 4);
    repeat (100) @(negedge clk);
    wr(A_GO, 32'h8);
    finish_read("R9", 8'h03, 24'h0F0F0F, 0, 0, 4);
    repeat (20) @(negedge clk);
    chk("R9", "no second read", 32'(spi_cs_n), 32'd1);

    // Abort part way through
    launch(8'h03, 24'h111111, 32'h0, 16'd7, 32'h0010_0000, 0, 8);
    repeat (150) @(negedge clk);
    wr(A_CTL, 32'h20);
    chk("R12", "chip select after abort", 32'(spi_cs_n), 32'd1);
    exp_addr.delete(); exp_data.delete();
    repeat (600) @(negedge clk);
    rd(A_STAT, d); chk("R12", "no done after abort", d, 32'h0);
    chk("R12", "stays idle after abort", 32'(spi_cs_n), 32'd1);

    // Length clamp at 1024 words, top of address space
    launch(8'h03, 24'h000042, 32'h0, 16'hFFFF, 32'hFFFF_F000, 0, 1024);
    finish_read("R7", 8'h03, 24'h000042, 0, 0, 1024);

    summary();
  end

endmodule